// File: doc/BRIEF.md
# Calendar-Ordered Flow Status Sender

This block drives a 2-bit flow-control status bus on behalf of a set of receive FIFOs. Each channel has a 2-bit status register that a host updates one channel at a time. Once running, the block emits a repeating pass made of one framing word followed by a run of status slots. The order of the slots comes from a small loadable calendar: each calendar entry names the channel whose status fills that slot, and the whole calendar is walked a parameterized number of times per pass.

After reset the block sends nothing but the framing word. A pulse input marks each complete training pattern seen on the data side, and a saturating counter tallies these pulses. When the tally reaches a configured target, the block leaves framing mode for good and starts the status passes. The calendar may be rewritten only while the block is still framing. This means a host can load the calendar after reset and before the training target is reached.

Top module: `flowStatusSender`

## Requirements
- R1: While reset is held and just after it, `statOut` is 11 and `sending` is 0. Every channel status resets to 00. Calendar entry i resets to channel i mod NUM_CH.
- R2: While `sending` is 0, `statOut` is 11 on every cycle.
- R3: Each cycle with `trainDone` high adds one to the training count. `sending` rises at the clock edge after the edge at which the count first reaches or exceeds `trainTarget`. It then stays high until reset.
- R4: A calendar write (`calWrEn`, entry `calWrAddr`, channel `calWrChan`) takes effect while `sending` is 0. It is ignored while `sending` is 1.
- R5: While sending, the output repeats a pass. Each pass is one framing word 11 followed by CAL_LEN*CAL_REPS slots, which walk calendar entries 0 to CAL_LEN-1 in order, CAL_REPS times. The first cycle with `sending` high carries the framing word.
- R6: A slot carries the 2-bit status of the channel named by its calendar entry. The codes are 10 satisfied, 01 hungry and 00 starving.
- R7: A status write (`statWrEn`, `statWrChan`, `statWrCode`) is visible from the next clock edge. A write made in the cycle its channel's slot is on the bus leaves that slot unchanged and shows at the channel's next slot.
- R8: A status write with code 11 is ignored, and the channel keeps its previous code.
- R9: The training count saturates at 2^CNT_W-1. With a target of 255, the block starts after the 255th pulse and not before.
- R10: With a target of 0, `sending` is high after the first clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trainDone | input | 1 | One-cycle pulse per complete training pattern |
| trainTarget | input | CNT_W | Training patterns required before status starts |
| statWrEn | input | 1 | Channel status write strobe |
| statWrChan | input | $clog2(NUM_CH) | Channel written |
| statWrCode | input | 2 | New status code (11 ignored) |
| calWrEn | input | 1 | Calendar write strobe, honoured while framing |
| calWrAddr | input | $clog2(CAL_LEN) | Calendar entry written |
| calWrChan | input | $clog2(NUM_CH) | Channel named by that entry |
| statOut | output | 2 | Status bus |
| sending | output | 1 | High once status passes have started |

## Verification
The two functions that can coincide are a host status write and the slot that sends the same channel. The bench drives a write for a channel in exactly the cycle that channel's slot is on the bus. It checks that the slot keeps the old code and that the channel's next slot, later in the same pass, carries the new one. A calendar write is also issued in the middle of a running pass. The following passes must still follow the calendar that was loaded before start.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam logic [1:0] CODE_FRAME     = 2'b11;
  localparam logic [1:0] CODE_SATISFIED = 2'b10;
  localparam logic [1:0] CODE_HUNGRY    = 2'b01;
  localparam logic [1:0] CODE_STARVING  = 2'b00;

  // strobes from the control to the datapath
  typedef struct packed {
    logic running;    // status passes under way
    logic frameSlot;  // current cycle carries the framing word
    logic calWrOk;    // calendar may be rewritten
  } ctrlStrobes_t;
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
#(
  parameter int CAL_LEN  = 16,
  parameter int CAL_REPS = 1,
  parameter int CNT_W    = 8,
  localparam int CAL_AW  = $clog2(CAL_LEN > 1 ? CAL_LEN : 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trainDone,
  input  logic [CNT_W-1:0]  trainTarget,
  output ctrlStrobes_t      strobes,
  output logic [CAL_AW-1:0] calIdx
);
  logic [CNT_W-1:0] trainCnt;
  logic             running;
  logic             atFrame;
  logic             lastEntry;
  logic             passEnd;

  // saturating tally of training patterns
  always_ff @(posedge clk) begin
    if (!rstN)
      trainCnt <= '0;
    else if (trainDone && (trainCnt != {CNT_W{1'b1}}))
      trainCnt <= trainCnt + 1'b1;
  end

  // one-way switch from framing to status passes
  always_ff @(posedge clk) begin
    if (!rstN)
      running <= 1'b0;
    else if (!running && (trainCnt >= trainTarget))
      running <= 1'b1;
  end

  assign lastEntry = (calIdx == CAL_AW'(CAL_LEN - 1));

  generate
    if (CAL_REPS > 1) begin : g_reps
      localparam int REP_W = $clog2(CAL_REPS);
      logic [REP_W-1:0] repCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !running || atFrame)
          repCnt <= '0;
        else if (lastEntry)
          repCnt <= passEnd ? '0 : repCnt + 1'b1;
      end
      assign passEnd = lastEntry && (repCnt == REP_W'(CAL_REPS - 1));
    end else begin : g_single
      assign passEnd = lastEntry;
    end
  endgenerate

  // slot sequencing: frame word, then calendar walks
  always_ff @(posedge clk) begin
    if (!rstN || !running) begin
      atFrame <= 1'b1;
      calIdx  <= '0;
    end else if (atFrame) begin
      atFrame <= 1'b0;
      calIdx  <= '0;
    end else begin
      calIdx  <= lastEntry ? '0 : calIdx + 1'b1;
      atFrame <= passEnd;
    end
  end

  always_comb begin
    strobes.running   = running;
    strobes.frameSlot = !running || atFrame;
    strobes.calWrOk   = !running;
  end
endmodule

// File: rtl/fss_dp.sv
module fss_dp
  import fss_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int CAL_LEN  = 16,
  localparam int CH_W    = $clog2(NUM_CH > 1 ? NUM_CH : 2),
  localparam int CAL_AW  = $clog2(CAL_LEN > 1 ? CAL_LEN : 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CAL_AW-1:0] calIdx,
  input  logic              statWrEn,
  input  logic [CH_W-1:0]   statWrChan,
  input  logic [1:0]        statWrCode,
  input  logic              calWrEn,
  input  logic [CAL_AW-1:0] calWrAddr,
  input  logic [CH_W-1:0]   calWrChan,
  output logic [1:0]        statOut
);
  logic [NUM_CH-1:0][1:0]      chanStat;
  logic [CAL_LEN-1:0][CH_W-1:0] calMem;
  logic [CH_W-1:0]             slotChan;
  logic                        statWrLegal;
  logic                        calWrLegal;

  assign statWrLegal = statWrEn && (int'(statWrChan) < NUM_CH) && (statWrCode != CODE_FRAME);
  assign calWrLegal  = calWrEn && strobes.calWrOk && (int'(calWrAddr) < CAL_LEN)
                       && (int'(calWrChan) < NUM_CH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) chanStat[c] <= CODE_STARVING;
    end else if (statWrLegal) begin
      chanStat[statWrChan] <= statWrCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < CAL_LEN; e++) calMem[e] <= CH_W'(e % NUM_CH);
    end else if (calWrLegal) begin
      calMem[calWrAddr] <= calWrChan;
    end
  end

  assign slotChan = calMem[calIdx];
  assign statOut  = strobes.frameSlot ? CODE_FRAME : chanStat[slotChan];
endmodule

// File: rtl/flowStatusSender.sv
module flowStatusSender
  import fss_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int CAL_LEN  = 16,
  parameter int CAL_REPS = 1,
  parameter int CNT_W    = 8,
  localparam int CH_W    = $clog2(NUM_CH > 1 ? NUM_CH : 2),
  localparam int CAL_AW  = $clog2(CAL_LEN > 1 ? CAL_LEN : 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trainDone,
  input  logic [CNT_W-1:0]  trainTarget,
  input  logic              statWrEn,
  input  logic [CH_W-1:0]   statWrChan,
  input  logic [1:0]        statWrCode,
  input  logic              calWrEn,
  input  logic [CAL_AW-1:0] calWrAddr,
  input  logic [CH_W-1:0]   calWrChan,
  output logic [1:0]        statOut,
  output logic              sending
);
  ctrlStrobes_t      strobes;
  logic [CAL_AW-1:0] calIdx;

  fss_ctrl #(.CAL_LEN(CAL_LEN), .CAL_REPS(CAL_REPS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trainDone(trainDone), .trainTarget(trainTarget),
    .strobes(strobes), .calIdx(calIdx)
  );

  fss_dp #(.NUM_CH(NUM_CH), .CAL_LEN(CAL_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .calIdx(calIdx),
    .statWrEn(statWrEn), .statWrChan(statWrChan), .statWrCode(statWrCode),
    .calWrEn(calWrEn), .calWrAddr(calWrAddr), .calWrChan(calWrChan),
    .statOut(statOut)
  );

  assign sending = strobes.running;
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int CAL_LEN  = 16,
  parameter int CAL_REPS = 1,
  parameter int CNT_W    = 8,
  parameter int CAL_BITS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                sending,
  input logic [1:0]          statOut,
  input logic [CNT_W-1:0]    trainCnt,
  input logic [CAL_BITS-1:0] calBits
);
  localparam int SEQ_LEN = CAL_LEN * CAL_REPS;
  logic [31:0] gap;

  // cycles since the last framing word while sending
  always_ff @(posedge clk) begin
    if (!rstN || !sending) gap <= 32'(SEQ_LEN);
    else if (statOut == 2'b11) gap <= 32'd0;
    else gap <= gap + 32'd1;
  end

  AST_IDLE_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    !sending |-> statOut == 2'b11); // R2
  AST_SEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    sending |=> sending); // R3
  AST_PASS_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    sending |-> ((statOut == 2'b11) == (gap == 32'(SEQ_LEN)))); // R5
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    trainCnt == {CNT_W{1'b1}} |=> trainCnt == {CNT_W{1'b1}}); // R9
  AST_CAL_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    sending |=> $stable(calBits)); // R4
endmodule

bind flowStatusSender fss_checker #(
  .CAL_LEN(CAL_LEN), .CAL_REPS(CAL_REPS), .CNT_W(CNT_W), .CAL_BITS(CAL_LEN * CH_W)
) u_chk (
  .clk(clk), .rstN(rstN), .sending(sending), .statOut(statOut),
  .trainCnt(u_ctrl.trainCnt), .calBits(u_dp.calMem)
);

// File: tb/sim_flowStatusSender.sv
`timescale 1ns/1ps
module sim_flowStatusSender;
  localparam int NCH = 4, CLEN = 6, REPS = 2, P = 1 + CLEN * REPS;

  logic clk = 1'b0, rstN = 1'b0, trainDone = 1'b0;
  logic [7:0] trainTarget = 8'd0;
  logic statWrEn = 1'b0, calWrEn = 1'b0;
  logic [1:0] statWrChan = '0, statWrCode = '0, calWrChan = '0;
  logic [2:0] calWrAddr = '0;
  logic [1:0] statOut;
  logic sending;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [1:0] expStat [NCH];
  logic [1:0] expCal [CLEN];

  always #4 clk = ~clk;

  flowStatusSender #(.NUM_CH(NCH), .CAL_LEN(CLEN), .CAL_REPS(REPS), .CNT_W(8)) u0 (
    .clk(clk), .rstN(rstN), .trainDone(trainDone), .trainTarget(trainTarget),
    .statWrEn(statWrEn), .statWrChan(statWrChan), .statWrCode(statWrCode),
    .calWrEn(calWrEn), .calWrAddr(calWrAddr), .calWrChan(calWrChan),
    .statOut(statOut), .sending(sending)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; statWrEn = 0; calWrEn = 0; trainDone = 0;
    repeat (3) @(negedge clk);
    chk(statOut == 2'b11 && sending == 1'b0, "R1 reset outputs", {sending, statOut}, 3);
    for (int c = 0; c < NCH; c++) expStat[c] = 2'b00;
    for (int e = 0; e < CLEN; e++) expCal[e] = 2'(e % NCH);
    rstN = 1'b1;
  endtask

  task automatic writeStat(input int ch, input logic [1:0] code);
    @(negedge clk);
    statWrEn = 1; statWrChan = 2'(ch); statWrCode = code;
    @(negedge clk);
    statWrEn = 0;
    if (code != 2'b11) expStat[ch] = code;
  endtask

  task automatic writeCal(input int addr, input int ch);
    @(negedge clk);
    calWrEn = 1; calWrAddr = 3'(addr); calWrChan = 2'(ch);
    @(negedge clk);
    calWrEn = 0;
    expCal[addr] = 2'(ch);
  endtask

  task automatic pulse();
    @(negedge clk); trainDone = 1;
    @(negedge clk); trainDone = 0;
  endtask

  // caller stands at the negedge where sending is first seen high
  task automatic stream(input int periods, input bit drives);
    for (int n = 0; n < periods * P; n++) begin
      int m;
      logic [1:0] ex;
      if (n > 0) @(negedge clk);
      m = n % P;
      ex = (m == 0) ? 2'b11 : expStat[expCal[(m - 1) % CLEN]];
      chk(statOut == ex, (m == 0) ? "R5 framing word" : "R6 slot code (R7/R4/R8)",
          statOut, ex);
      statWrEn = 0; calWrEn = 0;
      if (drives && n == 5) begin
        // R4: rewrite while running, must be ignored
        calWrEn = 1; calWrAddr = 3'd1; calWrChan = 2'd3;
      end
      if (drives && n == P + 1) begin
        // R7: write the channel whose slot is on the bus now
        statWrEn = 1; statWrChan = expCal[0]; statWrCode = 2'b01;
        expStat[expCal[0]] = 2'b01;
      end
    end
    @(negedge clk);
    statWrEn = 0; calWrEn = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // Test A: custom calendar, target 2, coincident write
    trainTarget = 8'd2;
    doReset();
    writeStat(0, 2'b01); writeStat(1, 2'b10); writeStat(3, 2'b10);
    writeStat(2, 2'b11);  // R8 reserved code ignored, ch2 stays 00
    writeCal(0, 2); writeCal(1, 0); writeCal(2, 3);
    writeCal(3, 3); writeCal(4, 1); writeCal(5, 0);
    chk(statOut == 2'b11 && !sending, "R2 framing before target", statOut, 3);
    pulse();
    chk(!sending && statOut == 2'b11, "R2 framing after one pulse", sending, 0);
    pulse();
    chk(!sending, "R3 not yet sending at count edge", sending, 0);
    @(negedge clk);
    chk(sending, "R3 sending one edge after count reached", sending, 1);
    stream(3, 1'b1);
    chk(sending, "R3 sending stays high", sending, 1);

    // Test B: target 0
    trainTarget = 8'd0;
    doReset();
    @(negedge clk);
    chk(sending && statOut == 2'b11, "R10 start right after reset", {sending, statOut}, 7);
    @(negedge clk);
    chk(statOut == 2'b00, "R1 reset status starving", statOut, 0);

    // Test C: target 255, default calendar
    trainTarget = 8'd255;
    doReset();
    writeStat(0, 2'b01); writeStat(1, 2'b10); writeStat(3, 2'b01);
    for (int k = 0; k < 254; k++) pulse();
    chk(!sending, "R9 not sending after 254 pulses", sending, 0);
    pulse();
    chk(!sending, "R9 count edge", sending, 0);
    @(negedge clk);
    chk(sending, "R9 sending after 255 pulses", sending, 1);
    stream(1, 1'b0);  // R1 identity calendar

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule